// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor whose register set is organised as overlapping windows. A 5-bit architectural register number is translated into a flat physical slot. The translation uses two pieces of context: the current window pointer, and a global-level selector that picks one of several global banks. The 32 visible registers fall into four groups of eight: globals, outs, locals and ins. When the window pointer advances by one, the new window's ins use the same storage as the previous window's outs. This lets a caller pass arguments to a callee without copying them.

The block has one combinational read port and one clocked write port. It takes a window-pointer input and a global-level input, and both are registered at each clock edge. A synchronous clear zeroes all storage. The physical slot chosen for the read address is also brought out, so that the mapping can be checked directly. Global banks fill the lowest physical slots and window segments follow them.

Top module: `wrf_top`

## Requirements
- R1: Bits [4:3] of a register number select the group: 0 is globals, 1 is outs, 2 is locals and 3 is ins. Bits [2:0] select the register within the group and appear unchanged as bits [2:0] of the physical slot.
- R2: Let w be the registered window pointer, taken modulo NWIN, and let b = ((NWIN - w) mod NWIN) * 2. Outs use segment b, locals use segment b+1 and ins use segment (b+2) mod (2*NWIN). The physical slot of a register in a window group is NGL*8 + segment*8 + offset.
- R3: The ins of window (w+1) mod NWIN occupy the same storage as the outs of window w. This includes the wrap between window 0 and window NWIN-1.
- R4: Globals come from the bank given by the registered global level g, at physical slot g*8 + offset. A level of NGL or above selects bank NGL-1.
- R5: A change of window pointer or global level only changes the mapping. No stored value is moved or altered.
- R6: The window pointer and global level are registered at each rising clock edge. A write in the cycle where either input changes uses the mapping in force before that edge. Reads and the physical slot output follow the registered mapping combinationally.
- R7: A write with the write enable high stores the data at the edge. From the next cycle, a read of the same register under the same mapping returns that data.
- R8: Register number 0 always reads as zero, and writes to it are dropped, at every global level.
- R9: The synchronous clear zeroes every global bank and every window segment at the edge. It takes priority over a write in the same cycle.
- R10: After reset the window pointer and global level are 0 and all storage reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all storage |
| cwp_i | input | CW (5) | Window pointer for the next cycle |
| gl_i | input | GW (2) | Global level for the next cycle |
| rd_addr_i | input | 5 | Read register number |
| rd_data_o | output | XLEN (32) | Read data |
| rd_phys_o | output | PW (10) | Physical slot of the read register |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Write register number |
| wr_data_i | input | XLEN (32) | Write data |

## Verification
The bench goes after the overlap between adjacent windows and the wrap at window 0. A design with the ins offset wrong, or one that left out the modulo on the ins segment, would return the wrong data or step outside the array. It also checks global-level saturation and bank isolation; a wrong design here would read a neighbouring bank or a window segment. It writes in the same cycle as a window change, where a design that used the new mapping would put the value in the wrong window. It also covers clear colliding with a write and writes to register 0, which would show up as stale data after clear or as a non-zero read of register 0.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  typedef enum logic [1:0] {
    FR_GLB = 2'd0,
    FR_OUT = 2'd1,
    FR_LOC = 2'd2,
    FR_IN  = 2'd3
  } frame_e;

  localparam int unsigned GRP_REGS = 8;
  localparam int unsigned OFF_W    = 3;
  localparam int unsigned ARCH_W   = 5;
endpackage

// File: rtl/wrf_ctx.sv
module wrf_ctx #(
  parameter int unsigned NWIN = 32,
  parameter int unsigned NGL  = 3,
  parameter int unsigned CW   = 5,
  parameter int unsigned GW   = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cwp_i,
  input  logic [GW-1:0] gl_i,
  output logic [CW-1:0] cwp_o,
  output logic [GW-1:0] gl_o
);
  logic [CW-1:0] cwp_red;
  logic [GW-1:0] gl_sat;

  // cwp_i < 2*NWIN, so a single subtract reduces it
  always_comb begin
    if (32'(cwp_i) >= NWIN) cwp_red = CW'(32'(cwp_i) - NWIN);
    else                    cwp_red = cwp_i;
    if (32'(gl_i) >= NGL)   gl_sat  = GW'(NGL - 1);
    else                    gl_sat  = gl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_o <= '0;
      gl_o  <= '0;
    end else begin
      cwp_o <= cwp_red;
      gl_o  <= gl_sat;
    end
  end
endmodule

// File: rtl/wrf_map.sv
module wrf_map
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN = 32,
  parameter int unsigned NGL  = 3,
  parameter int unsigned CW   = 5,
  parameter int unsigned GW   = 2,
  parameter int unsigned PW   = 10
) (
  input  logic [CW-1:0]     cwp_i,
  input  logic [GW-1:0]     gl_i,
  input  logic [ARCH_W-1:0] addr_i,
  output logic [PW-1:0]     phys_o
);
  localparam int unsigned NSEG     = 2 * NWIN;
  localparam int unsigned WIN_BASE = NGL * GRP_REGS;

  frame_e      fr;
  int unsigned base;
  int unsigned seg;
  int unsigned off;

  always_comb begin
    fr   = frame_e'(addr_i[ARCH_W-1:OFF_W]);
    off  = 32'(addr_i[OFF_W-1:0]);
    base = (cwp_i == '0) ? 0 : (NWIN - 32'(cwp_i)) * 2;
    seg  = base;
    unique case (fr)
      FR_OUT: seg = base;
      FR_LOC: seg = base + 1;
      FR_IN:  seg = ((base + 2) == NSEG) ? 0 : base + 2;
      default: seg = base;
    endcase
    if (fr == FR_GLB) phys_o = PW'(32'(gl_i) * GRP_REGS + off);
    else              phys_o = PW'(WIN_BASE + seg * GRP_REGS + off);
  end
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
  parameter int unsigned NPHYS = 536,
  parameter int unsigned PW    = 10,
  parameter int unsigned XLEN  = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            we_i,
  input  logic [PW-1:0]   wphys_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [PW-1:0]   rphys_i,
  input  logic            rzero_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] mem_q [NPHYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPHYS; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < NPHYS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[wphys_i] <= wdata_i;
    end
  end

  assign rdata_o = rzero_i ? '0 : mem_q[rphys_i];
endmodule

// File: rtl/wrf_top.sv
module wrf_top
  import wrf_pkg::*;
#(
  parameter int unsigned NWIN  = 32,
  parameter int unsigned NGL   = 3,
  parameter int unsigned XLEN  = 32,
  localparam int unsigned CW    = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int unsigned GW    = (NGL > 1) ? $clog2(NGL) : 1,
  localparam int unsigned NPHYS = (NGL + 2 * NWIN) * GRP_REGS,
  localparam int unsigned PW    = $clog2(NPHYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [CW-1:0]     cwp_i,
  input  logic [GW-1:0]     gl_i,
  input  logic [ARCH_W-1:0] rd_addr_i,
  output logic [XLEN-1:0]   rd_data_o,
  output logic [PW-1:0]     rd_phys_o,
  input  logic              wr_en_i,
  input  logic [ARCH_W-1:0] wr_addr_i,
  input  logic [XLEN-1:0]   wr_data_i
);
  logic [CW-1:0]     cwp_q;
  logic [GW-1:0]     gl_q;
  logic [ARCH_W-1:0] port_addr [2];
  logic [PW-1:0]     port_phys [2];
  logic              wr_ok;

  wrf_ctx #(.NWIN(NWIN), .NGL(NGL), .CW(CW), .GW(GW)) u_ctx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cwp_i (cwp_i),
    .gl_i  (gl_i),
    .cwp_o (cwp_q),
    .gl_o  (gl_q)
  );

  assign port_addr[0] = rd_addr_i;
  assign port_addr[1] = wr_addr_i;

  // one translator per port, both on the registered mapping
  for (genvar p = 0; p < 2; p++) begin : g_map
    wrf_map #(.NWIN(NWIN), .NGL(NGL), .CW(CW), .GW(GW), .PW(PW)) u_map (
      .cwp_i (cwp_q),
      .gl_i  (gl_q),
      .addr_i(port_addr[p]),
      .phys_o(port_phys[p])
    );
  end

  assign wr_ok = wr_en_i && (wr_addr_i != '0);

  wrf_store #(.NPHYS(NPHYS), .PW(PW), .XLEN(XLEN)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .we_i   (wr_ok),
    .wphys_i(port_phys[1]),
    .wdata_i(wr_data_i),
    .rphys_i(port_phys[0]),
    .rzero_i(rd_addr_i == '0),
    .rdata_o(rd_data_o)
  );

  assign rd_phys_o = port_phys[0];
endmodule

// File: rtl/wrf_chk.sv
module wrf_chk #(
  parameter int unsigned NWIN = 32,
  parameter int unsigned NGL  = 3,
  parameter int unsigned XLEN = 32,
  parameter int unsigned PW   = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            clr_i,
  input logic [4:0]      rd_addr_i,
  input logic [XLEN-1:0] rd_data_o,
  input logic [PW-1:0]   rd_phys_o
);
  localparam int unsigned NPHYS = (NGL + 2 * NWIN) * 8;

  // R8
  r0_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_i == 5'd0 |-> rd_data_o == '0);

  // R9
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> rd_data_o == '0);

  // R4
  glb_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_i[4:3] == 2'd0 |-> 32'(rd_phys_o) < NGL * 8);

  // R2
  win_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_i[4:3] != 2'd0 |-> (32'(rd_phys_o) >= NGL * 8) && (32'(rd_phys_o) < NPHYS));

  // R1
  off_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_phys_o[2:0] == rd_addr_i[2:0]);
endmodule

bind wrf_top wrf_chk #(.NWIN(NWIN), .NGL(NGL), .XLEN(XLEN), .PW(PW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o),
  .rd_phys_o(rd_phys_o)
);

// File: tb/sim_wrf_top.sv
module sim_wrf_top;
  localparam int NWIN  = 32;
  localparam int NGL   = 3;
  localparam int NPHYS = (NGL + 2 * NWIN) * 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic [4:0]  cwp_i = '0;
  logic [1:0]  gl_i = '0;
  logic [4:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [9:0]  rd_phys_o;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mdl [NPHYS];
  int m_cwp = 0;
  int m_gl = 0;

  always #10 clk_i = ~clk_i;

  wrf_top u0 (.*);

  function automatic int ref_phys(int cwp, int gl, int a);
    int fr, off, b, seg;
    fr  = a / 8;
    off = a % 8;
    if (fr == 0) return gl * 8 + off;
    b = ((NWIN - cwp) % NWIN) * 2;
    if (fr == 1) seg = b;
    else if (fr == 2) seg = b + 1;
    else seg = (b + 2) % (2 * NWIN);
    return NGL * 8 + seg * 8 + off;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, let the edge pass, update model
  task automatic step(string tag, bit we, int wa, int wd, int ra, int cwp, int gl, bit clr);
    int p;
    wr_en_i = we; wr_addr_i = 5'(wa); wr_data_i = 32'(wd);
    rd_addr_i = 5'(ra); cwp_i = 5'(cwp); gl_i = 2'(gl); clr_i = clr;
    #1;
    p = ref_phys(m_cwp, m_gl, ra);
    chk({tag, " phys"}, rd_phys_o, p);
    chk({tag, " data"}, rd_data_o, (ra == 0) ? 0 : mdl[p]);
    @(posedge clk_i);
    if (clr) begin
      for (int i = 0; i < NPHYS; i++) mdl[i] = '0;
    end else if (we && wa != 0) begin
      mdl[ref_phys(m_cwp, m_gl, wa)] = 32'(wd);
    end
    m_cwp = cwp % NWIN;
    m_gl = (gl >= NGL) ? NGL - 1 : gl;
    @(negedge clk_i);
  endtask

  task automatic peek(string tag, int ra, int exp_data);
    rd_addr_i = 5'(ra);
    #1;
    chk(tag, rd_data_o, exp_data);
  endtask

  task automatic peek_phys(string tag, int ra, int exp_p);
    rd_addr_i = 5'(ra);
    #1;
    chk(tag, rd_phys_o, exp_p);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NPHYS; i++) mdl[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R10: reset state, every register zero, window 0 / level 0 mapping
    for (int a = 0; a < 32; a++) step("R10", 0, 0, 0, a, 0, 0, 0);

    // R7: fill and read back at window 0, level 0
    for (int a = 0; a < 32; a++) step("R7 wr", 1, a, 32'h100 + a, a, 0, 0, 0);
    for (int a = 0; a < 32; a++) step("R7 rd", 0, 0, 0, a, 0, 0, 0);
    peek("R8", 0, 0);

    // R3: ins of window 1 are the outs of window 0
    step("R3", 0, 0, 0, 0, 1, 0, 0);
    peek("R3", 24, 32'h108);
    peek("R3", 31, 32'h10f);
    // R2: explicit slot at window 3, locals offset 0
    step("R2", 0, 0, 0, 0, 3, 0, 0);
    peek_phys("R2", 16, 24 + 59 * 8);
    peek_phys("R2", 24, 24 + 60 * 8);
    // R3 wrap: outs of window 31 are ins of window 0
    step("R3", 0, 0, 0, 0, 31, 0, 0);
    step("R3", 1, 8, 32'hbeef, 8, 31, 0, 0);
    step("R3", 0, 0, 0, 8, 0, 0, 0);
    peek("R3", 24, 32'hbeef);
    peek_phys("R2", 24, 24 + 2 * 8);
    // R5: locals of window 0 untouched by the pointer moves
    peek("R5", 16, 32'h110);
    peek("R5", 23, 32'h117);

    // R4: separate global banks, saturation above NGL-1
    step("R4", 0, 0, 0, 1, 0, 1, 0);
    step("R4", 1, 1, 32'ha1, 1, 0, 1, 0);
    step("R4", 0, 0, 0, 1, 0, 2, 0);
    step("R4", 1, 1, 32'ha2, 1, 0, 2, 0);
    step("R4", 0, 0, 0, 1, 0, 0, 0);
    peek("R4", 1, 32'h101);
    step("R4", 0, 0, 0, 1, 0, 1, 0);
    peek("R4", 1, 32'ha1);
    peek_phys("R4", 1, 9);
    step("R4", 0, 0, 0, 1, 0, 3, 0);
    peek("R4", 1, 32'ha2);
    peek_phys("R4", 1, 17);

    // R8: writes to register 0 dropped at each level
    step("R8", 1, 0, 32'hffff, 0, 0, 1, 0);
    step("R8", 1, 0, 32'hffff, 0, 0, 2, 0);
    step("R8", 0, 0, 0, 0, 0, 2, 0);
    peek("R8", 0, 0);
    peek("R8", 1, 32'ha2);

    // R6: write in the same cycle as a pointer change uses the old window
    step("R6", 0, 0, 0, 0, 0, 0, 0);
    step("R6", 1, 9, 32'h5a5a, 9, 5, 0, 0);
    step("R6", 0, 0, 0, 9, 0, 0, 0);
    peek("R6", 9, 32'h5a5a);

    // R9: clear wins over a write in the same cycle
    step("R9", 1, 10, 32'h1234, 10, 0, 0, 1);
    peek("R9", 10, 0);
    peek("R9", 1, 0);
    step("R9", 0, 0, 0, 24, 0, 0, 0);
    peek("R9", 24, 0);

    // random traffic against the model (R2, R7)
    for (int n = 0; n < 3000; n++) begin
      step("R7 rand", bit'($urandom % 2), int'($urandom % 32), int'($urandom),
           int'($urandom % 32), int'($urandom % 32), int'($urandom % 4),
           bit'(($urandom % 64) == 0));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule